// File: doc/BRIEF.md
# Remote Atomic Update Engine

This block takes atomic update requests that come off a network receive queue and carries each one out as a read-modify-write on a local word-addressed memory. The memory is modelled inside the block behind a synchronous port: one read and one write per cycle, with one cycle of read latency.

Each request carries the following fields:
- an opcode;
- a word address;
- a 64-bit operand;
- a compare value, used only by compare-and-swap;
- a fetch flag, which asks for the prior memory word to be returned;
- a tag.

Requests flow through a short read stage and then a compute/write stage. Requests to different words can be accepted every cycle. A request whose word is still being updated further down the pipeline is held off, so the updates stay atomic with respect to each other.

Responses leave on a valid/ready channel in request order, and each carries the tag of its request. A static mode input, `ack_every`, selects a reliable mode in which every update is acknowledged. In the normal mode, a no-fetch update completes silently.

Top module: `atom_upd_engine`

## Requirements
- R1: Opcode 0 adds the operand to the memory word modulo 2^64. A carry out of bit 63 is dropped and nothing flags it.
- R2: Opcodes 1, 2 and 3 write back the bitwise AND, OR and XOR of the memory word and the operand.
- R3: When the fetch flag is set, the response carries the word as it was before the update, with status 0 (done). When the flag is clear and `ack_every` is low, an ADD/AND/OR/XOR updates memory and produces no response.
- R4: Opcode 4 is compare-and-swap. When the memory word equals the compare value, the operand is written. The response always occurs, whatever the fetch flag, and carries the old word with status 0.
- R5: When a compare-and-swap finds a word different from the compare value, memory is left unchanged. The response carries the old word with status 1 (compare miss).
- R6: Opcodes 5 to 7 are illegal. They always produce a response with status 2 (bad opcode) and data zero, and they leave memory unchanged.
- R7: With `ack_every` high, every request produces a response. A no-fetch ADD/AND/OR/XOR responds with status 0 and data zero.
- R8: Each response carries the tag of its request. Responses come out in the order the requests were accepted.
- R9: A request whose address matches an update still in the read or write stage is not accepted until that write has happened. With the response channel free, a same-address request is accepted exactly three cycles after its predecessor, and the chained updates compose correctly.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response holds its tag, status and data unchanged. No response is dropped.
- R11: After reset, `rsp_valid` is low, `req_ready` is high and every memory word reads zero.
- R12: With the response channel free, requests to addresses that are not in flight are accepted on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_every | input | 1 | Reliable mode: acknowledge every update (change only while idle) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_op | input | 3 | Opcode: 0 ADD, 1 AND, 2 OR, 3 XOR, 4 CAS, 5-7 illegal |
| req_fetch | input | 1 | Return the prior word |
| req_addr | input | $clog2(DEPTH) | Word address |
| req_operand | input | DATA_W | Operand, or swap value for CAS |
| req_compare | input | DATA_W | Compare value for CAS |
| req_tag | input | TAG_W | Request tag |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken on this edge when valid |
| rsp_tag | output | TAG_W | Tag copied from the request |
| rsp_status | output | 2 | 0 done, 1 compare miss, 2 bad opcode |
| rsp_data | output | DATA_W | Prior word, or zero |

## Verification
On every cycle, the assertions check four things:
- a held response stays stable under backpressure;
- the memory is never read and written at the same word in the same cycle, which is the same-address hazard the interlock must prevent;
- a bad-opcode response carries zero data;
- no response is pending right after reset.

The arithmetic and logic results, the compare-and-swap outcomes, the rule on when a response occurs, the untouched memory after illegal opcodes and compare misses, and the exact accept spacing for same-address and different-address traffic can only be shown by the bench's directed scenarios. The bench checks these against its own reference memory.

// File: rtl/atom_pkg.sv
package atom_pkg;

    localparam logic [2:0] OP_ADD = 3'd0;
    localparam logic [2:0] OP_AND = 3'd1;
    localparam logic [2:0] OP_OR  = 3'd2;
    localparam logic [2:0] OP_XOR = 3'd3;
    localparam logic [2:0] OP_CAS = 3'd4;

    typedef enum logic [1:0] {
        ST_DONE     = 2'd0,
        ST_CMP_MISS = 2'd1,
        ST_BAD_OP   = 2'd2
    } rsp_st_e;

    function automatic logic op_known(input logic [2:0] op);
        return op <= OP_CAS;
    endfunction

    // A response is owed for errors, swaps, fetches, or in reliable mode.
    function automatic logic rsp_wanted(input logic [2:0] op, input logic fetch,
                                        input logic ack_all);
        return !op_known(op) || (op == OP_CAS) || fetch || ack_all;
    endfunction

    // The prior word travels back only for legal swaps and fetches.
    function automatic logic returns_old(input logic [2:0] op, input logic fetch);
        return op_known(op) && ((op == OP_CAS) || fetch);
    endfunction

endpackage

// File: rtl/atom_mem.sv
module atom_mem #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata
);
    logic [DATA_W-1:0] word_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // A read and a write in the same cycle return the word as it was
    // before the write.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) word_q[i] <= '0;
            rdata_q <= '0;
        end else begin
            if (we) word_q[waddr] <= wdata;
            if (re) rdata_q <= word_q[raddr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/atom_alu.sv
module atom_alu
    import atom_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] compare,
    output logic [DATA_W-1:0] new_val,
    output logic              wr_en,
    output rsp_st_e           status
);
    always_comb begin
        new_val = old_val;
        wr_en   = 1'b1;
        status  = ST_DONE;
        case (op)
            OP_ADD: new_val = old_val + operand;
            OP_AND: new_val = old_val & operand;
            OP_OR:  new_val = old_val | operand;
            OP_XOR: new_val = old_val ^ operand;
            OP_CAS: begin
                if (old_val == compare) begin
                    new_val = operand;
                end else begin
                    wr_en  = 1'b0;
                    status = ST_CMP_MISS;
                end
            end
            default: begin
                wr_en  = 1'b0;
                status = ST_BAD_OP;
            end
        endcase
    end
endmodule

// File: rtl/atom_hazard.sv
module atom_hazard #(
    parameter int ADDR_W = 4,
    parameter int NSLOT  = 2
) (
    input  logic [NSLOT-1:0]             slot_valid,
    input  logic [NSLOT-1:0][ADDR_W-1:0] slot_addr,
    input  logic [ADDR_W-1:0]            probe_addr,
    output logic                         hit
);
    logic [NSLOT-1:0] hit_vec;

    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        assign hit_vec[g] = slot_valid[g] && (slot_addr[g] == probe_addr);
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/atom_upd_engine.sv
module atom_upd_engine
    import atom_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 16,
    parameter int TAG_W  = 6,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ack_every,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic              req_fetch,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_operand,
    input  logic [DATA_W-1:0] req_compare,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int NSLOT = 2;

    typedef struct packed {
        logic              v;
        logic [2:0]        op;
        logic              fetch;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] opnd;
        logic [DATA_W-1:0] cmp;
        logic [TAG_W-1:0]  tag;
    } slot_t;

    slot_t             s1_q, s2_q;
    logic [DATA_W-1:0] s2_old_q;

    logic              mem_re, mem_we;
    logic [ADDR_W-1:0] mem_raddr, mem_waddr;
    logic [DATA_W-1:0] mem_rdata, mem_wdata;

    logic [DATA_W-1:0] alu_new;
    logic              alu_wr;
    rsp_st_e           alu_st;

    logic                        haz_hit;
    logic [NSLOT-1:0]            slot_v;
    logic [NSLOT-1:0][ADDR_W-1:0] slot_a;

    logic s2_need, out_free, s2_go, s1_go, s1_room, acc;

    logic              rsp_valid_q;
    logic [TAG_W-1:0]  rsp_tag_q;
    logic [1:0]        rsp_st_q;
    logic [DATA_W-1:0] rsp_data_q;

    // Pipeline flow control, from the response end backwards
    assign s2_need  = rsp_wanted(s2_q.op, s2_q.fetch, ack_every);
    assign out_free = !rsp_valid_q || rsp_ready;
    assign s2_go    = s2_q.v && (!s2_need || out_free);
    assign s1_go    = s1_q.v && (!s2_q.v || s2_go);
    assign s1_room  = !s1_q.v || s1_go;

    // Both stages hold an address whose write has not landed yet.
    assign slot_v = {s2_q.v, s1_q.v};
    assign slot_a = {s2_q.addr, s1_q.addr};

    atom_hazard #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u_haz (
        .slot_valid (slot_v),
        .slot_addr  (slot_a),
        .probe_addr (req_addr),
        .hit        (haz_hit)
    );

    assign req_ready = !rst && s1_room && !haz_hit;
    assign acc       = req_valid && req_ready;

    assign mem_re    = acc;
    assign mem_raddr = req_addr;

    atom_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (s2_q.op),
        .old_val (s2_old_q),
        .operand (s2_q.opnd),
        .compare (s2_q.cmp),
        .new_val (alu_new),
        .wr_en   (alu_wr),
        .status  (alu_st)
    );

    assign mem_we    = s2_go && alu_wr;
    assign mem_waddr = s2_q.addr;
    assign mem_wdata = alu_new;

    atom_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (mem_rdata),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q        <= '0;
            s2_q        <= '0;
            s2_old_q    <= '0;
            rsp_valid_q <= 1'b0;
            rsp_tag_q   <= '0;
            rsp_st_q    <= '0;
            rsp_data_q  <= '0;
        end else begin
            if (acc) begin
                s1_q <= '{v: 1'b1, op: req_op, fetch: req_fetch, addr: req_addr,
                          opnd: req_operand, cmp: req_compare, tag: req_tag};
            end else if (s1_go) begin
                s1_q.v <= 1'b0;
            end

            // The read issued on acceptance returns while s1 holds the request.
            // No new read is issued until s1 moves on, so the data stays put.
            if (s1_go) begin
                s2_q     <= s1_q;
                s2_old_q <= mem_rdata;
            end else if (s2_go) begin
                s2_q.v <= 1'b0;
            end

            if (s2_go && s2_need) begin
                rsp_valid_q <= 1'b1;
                rsp_tag_q   <= s2_q.tag;
                rsp_st_q    <= alu_st;
                rsp_data_q  <= returns_old(s2_q.op, s2_q.fetch) ? s2_old_q : '0;
            end else if (rsp_ready) begin
                rsp_valid_q <= 1'b0;
            end
        end
    end

    assign rsp_valid  = rsp_valid_q;
    assign rsp_tag    = rsp_tag_q;
    assign rsp_status = rsp_st_q;
    assign rsp_data   = rsp_data_q;
endmodule

// File: rtl/atom_upd_checker.sv
module atom_upd_checker #(
    parameter int DATA_W = 64,
    parameter int TAG_W  = 6,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [TAG_W-1:0]  rsp_tag,
    input logic [1:0]        rsp_status,
    input logic [DATA_W-1:0] rsp_data,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic [ADDR_W-1:0] mem_raddr
);
    // R10: a stalled response keeps its contents
    a_r10_rsp_hold: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_tag)
                                    && $stable(rsp_status) && $stable(rsp_data));

    // R9: the interlock never lets a read race a write to the same word
    a_r9_no_rw_collision: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re && (mem_waddr == mem_raddr)));

    // R6: an error response never carries data
    a_r6_bad_op_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && (rsp_status == 2'd2) |-> rsp_data == '0);

    // R11: nothing is pending right after reset
    a_r11_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid);
endmodule

bind atom_upd_engine atom_upd_checker #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_tag    (rsp_tag),
    .rsp_status (rsp_status),
    .rsp_data   (rsp_data),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_waddr  (mem_waddr),
    .mem_raddr  (mem_raddr)
);

// File: tb/test_atom_upd_engine.sv
module test_atom_upd_engine;
    localparam int DW = 64, DEPTH = 16, AW = 4, TW = 6, NMAX = 64;

    logic clk = 1'b0, rst = 1'b1, ack_every = 1'b0;
    logic req_valid = 1'b0, req_fetch = 1'b0, rsp_ready = 1'b1;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_operand = '0, req_compare = '0;
    logic [TW-1:0] req_tag = '0;
    logic          req_ready, rsp_valid;
    logic [TW-1:0] rsp_tag;
    logic [1:0]    rsp_status;
    logic [DW-1:0] rsp_data;

    atom_upd_engine #(.DATA_W(DW), .DEPTH(DEPTH), .TAG_W(TW)) i_atom_upd_engine (
        .clk(clk), .rst(rst), .ack_every(ack_every),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_fetch(req_fetch), .req_addr(req_addr), .req_operand(req_operand),
        .req_compare(req_compare), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag),
        .rsp_status(rsp_status), .rsp_data(rsp_data)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    logic [DW-1:0] ref_mem [DEPTH];

    logic [2:0]    s_op [NMAX];
    logic          s_f  [NMAX];
    logic [AW-1:0] s_a  [NMAX];
    logic [DW-1:0] s_x  [NMAX];
    logic [DW-1:0] s_c  [NMAX];
    logic [TW-1:0] s_t  [NMAX];
    int            acc_cyc [NMAX];
    int            s_cnt = 0;

    logic [TW-1:0] e_t [NMAX];
    logic [DW-1:0] e_d [NMAX];
    logic [1:0]    e_s [NMAX];
    string         e_r [NMAX];
    int            e_cnt = 0;

    logic [TW-1:0] next_tag = '0;
    int            ready_mode = 0;
    int            hold_seen = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Queue one request and work out its expected response from the requirements.
    task automatic add_req(input logic [2:0] op, input bit f, input int a,
                           input logic [DW-1:0] x, input logic [DW-1:0] c,
                           input string rq);
        logic [DW-1:0] old = ref_mem[a];
        logic [1:0] st = 2'd0;
        bit resp;
        case (op)
            3'd0: ref_mem[a] = old + x;
            3'd1: ref_mem[a] = old & x;
            3'd2: ref_mem[a] = old | x;
            3'd3: ref_mem[a] = old ^ x;
            3'd4: if (old == c) ref_mem[a] = x; else st = 2'd1;
            default: st = 2'd2;
        endcase
        s_op[s_cnt] = op; s_f[s_cnt] = f; s_a[s_cnt] = AW'(a);
        s_x[s_cnt] = x; s_c[s_cnt] = c; s_t[s_cnt] = next_tag;
        resp = (op > 3'd3) || f || ack_every;
        if (resp) begin
            e_t[e_cnt] = next_tag;
            e_s[e_cnt] = st;
            e_d[e_cnt] = (op > 3'd4) ? '0 : ((op == 3'd4 || f) ? old : '0);
            e_r[e_cnt] = rq;
            e_cnt++;
        end
        s_cnt++;
        next_tag = next_tag + 1'b1;
    endtask

    task automatic run_batch(input int mode, input string rq_extra);
        ready_mode = mode;
        @(negedge clk);
        fork
            begin
                for (int i = 0; i < s_cnt; i++) begin
                    req_valid = 1'b1; req_op = s_op[i]; req_fetch = s_f[i];
                    req_addr = s_a[i]; req_operand = s_x[i];
                    req_compare = s_c[i]; req_tag = s_t[i];
                    #1;
                    while (!req_ready) begin
                        @(negedge clk);
                        #1;
                    end
                    @(posedge clk);
                    acc_cyc[i] = cyc;
                    @(negedge clk);
                end
                req_valid = 1'b0;
            end
            begin
                int got = 0;
                bit pend = 0;
                logic [TW-1:0] h_t;
                logic [1:0]    h_s;
                logic [DW-1:0] h_d;
                while (got < e_cnt) begin
                    rsp_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) == 1);
                    #1;
                    if (pend) begin
                        hold_seen++;
                        chk(rsp_valid && rsp_tag == h_t && rsp_status == h_s && rsp_data == h_d,
                            "R10", "held response", rsp_data, h_d);
                        pend = 0;
                    end
                    if (rsp_valid && rsp_ready) begin
                        chk(rsp_tag == e_t[got], "R8", "tag", DW'(rsp_tag), DW'(e_t[got]));
                        chk(rsp_status == e_s[got], e_r[got], "status",
                            DW'(rsp_status), DW'(e_s[got]));
                        chk(rsp_data == e_d[got], e_r[got], "data", rsp_data, e_d[got]);
                        got++;
                    end else if (rsp_valid) begin
                        pend = 1; h_t = rsp_tag; h_s = rsp_status; h_d = rsp_data;
                    end
                    @(negedge clk);
                end
                rsp_ready = 1'b1;
            end
        join
        // Any response beyond the expected ones is an error.
        begin
            bit extra = 0;
            repeat (6) begin
                @(negedge clk);
                if (rsp_valid) extra = 1;
            end
            chk(!extra, rq_extra, "no unexpected response", DW'(extra), '0);
        end
    endtask

    task automatic clear_batch;
        s_cnt = 0;
        e_cnt = 0;
    endtask

    task automatic t_reset;
        chk(rsp_valid == 1'b0, "R11", "rsp_valid after reset", DW'(rsp_valid), '0);
        chk(req_ready == 1'b1, "R11", "req_ready after reset", DW'(req_ready), 1);
        clear_batch();
        add_req(3'd0, 1, 0, '0, '0, "R11");
        add_req(3'd0, 1, 7, '0, '0, "R11");
        add_req(3'd0, 1, 15, '0, '0, "R11");
        run_batch(0, "R11");
    endtask

    task automatic t_logic;
        clear_batch();
        add_req(3'd3, 1, 1, 64'hF0F0_1234_5678_00FF, '0, "R2");
        add_req(3'd1, 1, 1, 64'h0FF0_FFFF_0000_0F0F, '0, "R2");
        add_req(3'd2, 1, 1, 64'h8000_0000_0000_0001, '0, "R2");
        add_req(3'd3, 1, 1, 64'hFFFF_0000_FFFF_0000, '0, "R2");
        add_req(3'd0, 1, 1, '0, '0, "R2");
        run_batch(0, "R2");
    endtask

    task automatic t_add_wrap;
        clear_batch();
        add_req(3'd3, 1, 3, 64'hFFFF_FFFF_FFFF_FFFE, '0, "R1");
        add_req(3'd0, 1, 3, 64'd5, '0, "R1");
        add_req(3'd0, 1, 3, '0, '0, "R1");
        run_batch(0, "R1");
        chk(ref_mem[3] == 64'd3, "R1", "wrapped sum", ref_mem[3], 64'd3);
    endtask

    task automatic t_cas;
        clear_batch();
        add_req(3'd4, 0, 4, 64'h1234, 64'h0, "R4");
        add_req(3'd4, 0, 4, 64'h9999, 64'h0, "R5");
        add_req(3'd4, 1, 4, 64'h7777, 64'h1234, "R4");
        add_req(3'd0, 1, 4, '0, '0, "R5");
        run_batch(0, "R5");
    endtask

    task automatic t_bad_op;
        clear_batch();
        add_req(3'd6, 1, 4, 64'hFFFF, '0, "R6");
        add_req(3'd7, 0, 4, 64'hFFFF, '0, "R6");
        add_req(3'd5, 0, 4, 64'h1, 64'h7777, "R6");
        add_req(3'd0, 1, 4, '0, '0, "R6");
        run_batch(0, "R6");
    endtask

    task automatic t_nofetch;
        clear_batch();
        add_req(3'd0, 0, 5, 64'd7, '0, "R3");
        add_req(3'd3, 0, 5, 64'd1, '0, "R3");
        add_req(3'd2, 0, 2, 64'hA0, '0, "R3");
        add_req(3'd0, 1, 5, '0, '0, "R3");
        add_req(3'd0, 1, 2, '0, '0, "R3");
        run_batch(0, "R3");
    endtask

    task automatic t_reliable;
        @(negedge clk);
        ack_every = 1'b1;
        clear_batch();
        add_req(3'd0, 0, 6, 64'd9, '0, "R7");
        add_req(3'd2, 0, 6, 64'h100, '0, "R7");
        add_req(3'd1, 0, 2, 64'hF0, '0, "R7");
        add_req(3'd0, 1, 6, '0, '0, "R7");
        run_batch(0, "R7");
        ack_every = 1'b0;
    endtask

    task automatic t_hazard;
        clear_batch();
        add_req(3'd0, 1, 8, 64'd1, '0, "R9");
        add_req(3'd0, 1, 8, 64'd2, '0, "R9");
        add_req(3'd0, 1, 8, 64'd4, '0, "R9");
        add_req(3'd0, 1, 9, 64'd1, '0, "R12");
        add_req(3'd0, 1, 10, 64'd1, '0, "R12");
        add_req(3'd0, 1, 11, 64'd1, '0, "R12");
        add_req(3'd0, 1, 8, '0, '0, "R9");
        run_batch(0, "R9");
        chk(acc_cyc[1] - acc_cyc[0] == 3, "R9", "same-address gap 1",
            DW'(acc_cyc[1] - acc_cyc[0]), 3);
        chk(acc_cyc[2] - acc_cyc[1] == 3, "R9", "same-address gap 2",
            DW'(acc_cyc[2] - acc_cyc[1]), 3);
        for (int i = 3; i < 6; i++)
            chk(acc_cyc[i] - acc_cyc[i-1] == 1, "R12", "different-address gap",
                DW'(acc_cyc[i] - acc_cyc[i-1]), 1);
    endtask

    task automatic t_backpressure;
        @(negedge clk);
        ack_every = 1'b1;
        hold_seen = 0;
        clear_batch();
        for (int i = 0; i < 12; i++)
            add_req(3'(i % 5), (i % 2) == 0, i, 64'(i * 3 + 1), 64'(i), "R8");
        add_req(3'd6, 0, 0, '0, '0, "R8");
        run_batch(1, "R10");
        chk(hold_seen > 0, "R10", "stall observed", DW'(hold_seen), 1);
        ack_every = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_logic();
        t_add_wrap();
        t_cas();
        t_bad_op();
        t_nofetch();
        t_reliable();
        t_hazard();
        t_backpressure();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule